// File: doc/BRIEF.md
# Booth Multiply-Accumulate Datapath

This block multiplies two signed 32-bit operands and adds the product to a 72-bit running total in one clock cycle. The multiplier operand is recoded into radix-4 Booth digits, and each digit selects a multiple of the multiplicand. The resulting partial products are reduced by a carry-save tree to two vectors. The stored total then joins those two vectors in one last carry-save row, so the product is never formed on its own. One carry-propagate adder turns the final pair into the new total.

A caller presents operands with `in_valid` high. With `clr_acc` also high, the accumulator is loaded with the bare product and the previous total is discarded. Otherwise the product is added to the total. The new total appears on `acc_out` one cycle later and `out_valid` flags it. The eight bits above the 64-bit product range let many full-scale products be summed before the total wraps.

Top module: `booth_mac`

## Requirements
- R1: The multiplier is split into 17 overlapping 3-bit groups, each sharing its lowest bit with the highest bit of the group below. Bit 0 of the lowest group is an implied zero, and the top group is filled with the sign bit. Each group maps to a digit in {-2,-1,0,+1,+2}, and the digits give the correct product for every operand pattern, including alternating bit patterns.
- R2: Operands are two's-complement signed. A product loaded with clear equals the exact signed product, including the most negative value times itself (2^62) and maximum times minimum.
- R3: With `in_valid` high and `clr_acc` low, the new `acc_out` equals the old `acc_out` plus the signed product, modulo 2^72.
- R4: With `in_valid` and `clr_acc` both high, the new `acc_out` equals the signed product, whatever the previous total was.
- R5: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R6: While `in_valid` is low, `acc_out` keeps its value, even if `clr_acc` is high or the operands change.
- R7: The accumulator keeps bits above bit 63. Four products of 2^62 give exactly 2^64, and 1024 of them wrap to zero.
- R8: While `rst_n` is low, `acc_out` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| clr_acc | input | 1 | With in_valid, load the product instead of adding it |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier (Booth recoded) |
| acc_out | output | 72 | Registered accumulator total |
| out_valid | output | 1 | acc_out was updated on the last edge |

## Verification
The bench builds the block with its default parameters: 32-bit operands and a 72-bit accumulator, which gives 17 Booth groups and eight guard bits. At this size the most negative operand squared, and alternating bit patterns that drive every Booth digit value, can be reached directly. Summing a run of 1024 full-scale products is also within reach. It carries the total past bit 64 and then wraps it exactly to zero, which exercises the guard bits and the modulo behaviour.

// File: rtl/booth_mac.sv
module booth_mac #(
  parameter int OPW  = 32,
  parameter int ACCW = 72
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            clr_acc,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic [ACCW-1:0] acc_out,
  output logic            out_valid
);
  localparam int NPP  = OPW / 2 + 1;
  localparam int NOPS = NPP + 1;

  logic [ACCW-1:0] a_ext, b_ext;
  logic [OPW+2:0]  b_grp;
  logic [ACCW-1:0] ops [NOPS];
  logic [ACCW-1:0] fix;
  logic [ACCW-1:0] t_sum, t_car;
  logic [ACCW-1:0] acc_in, s3, c3, acc_nxt;

  assign a_ext = {{(ACCW-OPW){op_a[OPW-1]}}, op_a};
  assign b_ext = {{(ACCW-OPW){op_b[OPW-1]}}, op_b};
  assign b_grp = {op_b[OPW-1], op_b[OPW-1], op_b, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [2:0]      g;
    logic            one, two, neg;
    logic [ACCW-1:0] mag;
    assign g   = b_grp[2*i+2 -: 3];
    assign one = g[1] ^ g[0];
    assign two = (g == 3'b011) | (g == 3'b100);
    assign neg = g[2] & ~(g[1] & g[0]);
    assign mag = one ? a_ext : (two ? {a_ext[ACCW-2:0], 1'b0} : '0);
    assign ops[i] = (neg ? ~mag : mag) << (2*i);
    assign fix[2*i]   = neg;
    assign fix[2*i+1] = 1'b0;
  end
  assign fix[ACCW-1:2*NPP] = '0;
  assign ops[NPP] = fix;

  always_comb begin
    logic [ACCW-1:0] cur [NOPS];
    logic [ACCW-1:0] nxt [NOPS];
    int n, k, idx;
    cur = ops;
    n = NOPS;
    for (int l = 0; l < NOPS; l++) begin
      if (n > 2) begin
        k = 0;
        nxt = '{default: '0};
        for (int g = 0; g < NOPS / 3; g++) begin
          if (3*g + 2 < n) begin
            nxt[k]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[k+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                        (cur[3*g+1] & cur[3*g+2])) << 1;
            k = k + 2;
          end
        end
        for (int r = 0; r < 2; r++) begin
          idx = 3 * (n / 3) + r;
          if (idx < n) begin
            nxt[k] = cur[idx];
            k = k + 1;
          end
        end
        cur = nxt;
        n = k;
      end
    end
    t_sum = cur[0];
    t_car = cur[1];
  end

  assign acc_in  = clr_acc ? '0 : acc_out;
  assign s3      = t_sum ^ t_car ^ acc_in;
  assign c3      = ((t_sum & t_car) | (t_sum & acc_in) | (t_car & acc_in)) << 1;
  assign acc_nxt = s3 + c3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) acc_out <= acc_nxt;
    end
  end

  // R1 R2
  tree_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (ACCW'(t_sum + t_car) == ACCW'(a_ext * b_ext)));
  // R3
  acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !clr_acc |=> acc_out == ACCW'($past(acc_out) + $past(ACCW'(a_ext * b_ext))));
  // R4
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && clr_acc |=> acc_out == $past(ACCW'(a_ext * b_ext)));
  // R5
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid & rst_n));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out));
endmodule

// File: tb/tb_booth_mac.sv
module tb_booth_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        clr_acc = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [71:0] acc_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  logic [71:0] model = '0;
  logic done = 1'b0;

  localparam logic [31:0] MINV = 32'h8000_0000;
  localparam logic [31:0] MAXV = 32'h7fff_ffff;

  booth_mac dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr_acc(clr_acc),
                 .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid));

  always #2.5 clk = ~clk;

  function automatic logic [71:0] prod(input logic [31:0] a, input logic [31:0] b);
    logic [71:0] ax, bx;
    ax = {{40{a[31]}}, a};
    bx = {{40{b[31]}}, b};
    return ax * bx;
  endfunction

  task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic clr,
                       input string tag);
    @(negedge clk);
    op_a = a; op_b = b; clr_acc = clr; in_valid = 1'b1;
    model = clr ? prod(a, b) : model + prod(a, b);
    @(negedge clk);
    in_valid = 1'b0; clr_acc = 1'b0;
    chk(tag, acc_out, model);
    chk("R5 valid after op", {71'd0, out_valid}, 72'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R8 acc in reset", acc_out, '0);
    chk("R8 valid in reset", {71'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 acc after reset", acc_out, '0);
    chk("R5 no valid after reset", {71'd0, out_valid}, '0);
  endtask

  task automatic t_corners;
    do_op(MINV, MINV, 1'b1, "R2 min*min");
    chk("R2 min*min is 2^62", acc_out, 72'd1 << 62);
    do_op(MAXV, MAXV, 1'b1, "R2 max*max");
    do_op(MAXV, MINV, 1'b1, "R2 max*min");
    do_op(MINV, MAXV, 1'b1, "R2 min*max");
    do_op(32'hffff_ffff, 32'hffff_ffff, 1'b1, "R2 -1*-1");
    do_op(32'h1234_5678, 32'h0, 1'b1, "R1 times zero");
    do_op(32'hdead_beef, 32'h1, 1'b1, "R1 times one");
    do_op(32'h1357_9bdf, 32'haaaa_aaaa, 1'b1, "R1 alt pattern A");
    do_op(32'hfedc_ba98, 32'h5555_5555, 1'b1, "R1 alt pattern 5");
    do_op(32'h0f0f_0f0f, 32'hcccc_cccc, 1'b1, "R1 pattern C");
    do_op(32'h8765_4321, 32'h3333_3333, 1'b1, "R1 pattern 3");
  endtask

  task automatic t_accum;
    do_op(32'd7, 32'd9, 1'b1, "R4 start");
    for (int i = 0; i < 24; i++)
      do_op($urandom, $urandom, 1'b0, "R3 random accumulate");
  endtask

  task automatic t_clear;
    do_op(32'h7fff_0000, 32'h7fff_0000, 1'b0, "R3 build total");
    do_op(32'hffff_fff3, 32'd11, 1'b1, "R4 clear load");
    chk("R4 clear value", acc_out, prod(32'hffff_fff3, 32'd11));
  endtask

  task automatic t_idle;
    @(negedge clk);
    clr_acc = 1'b1; in_valid = 1'b0; op_a = 32'h5; op_b = 32'h6;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_a = op_a + 32'd3;
      chk("R6 idle hold", acc_out, model);
      chk("R5 idle valid low", {71'd0, out_valid}, '0);
    end
    clr_acc = 1'b0;
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      if (k == 4) chk("R7 four max products 2^64", acc_out, 72'd1 << 64);
      in_valid = 1'b1; clr_acc = (k == 0); op_a = MINV; op_b = MINV;
      model = (k == 0) ? prod(MINV, MINV) : model + prod(MINV, MINV);
    end
    @(negedge clk);
    in_valid = 1'b0; clr_acc = 1'b0;
    chk("R7 wrap to zero", acc_out, '0);
    chk("R7 model agrees", acc_out, model);
  endtask

  initial begin
    t_reset;
    t_corners;
    t_accum;
    t_clear;
    t_idle;
    t_wrap;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule